// File: doc/BRIEF.md
# Level-2 Interrupt Aggregation Controller

This block collects a vector of edge-triggered interrupt sources and folds them into a single request line for a parent interrupt controller. Each source has a sticky pending bit, which a synchronised rising edge sets, and a mask bit in which a one disables the source. Software reads and changes both vectors over a simple word-aligned register bus. Each vector has one read-only status word and two write-one-only words, one to set bits and one to clear them. Software therefore never needs a read-modify-write sequence, and it can raise pending bits itself to trigger an interrupt from software.

The parent line is high while at least one pending source is unmasked. A service routine reads the pending word and the mask word, acknowledges each source it handles by writing that bit to the pending-clear word, and moves on to the next source. A build-time option swaps the four bytes of every bus word in both directions, for processors that expect big-endian register data.

Top module: `l2irq_ctrl`

## Requirements
- R1: After reset every mask bit reads 1 at offset 0x0C, every pending bit reads 0 at offset 0x00, and `irq_o` is low.
- R2: A rising edge on `src_i[n]` sets pending bit n (bit n of offset 0x00) at the third rising clock edge after the change. The bit stays set after the source falls, and a source held high does not set it again once it has been cleared.
- R3: Writing to offset 0x08 clears every pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value.
- R4: Writing to offset 0x04 sets every pending bit whose write-data bit is 1, whatever the state of the sources.
- R5: Writing to offset 0x10 sets mask bits, which disables those sources. Writing to offset 0x14 clears mask bits, which enables them. In both cases only the bits written as 1 change, and offset 0x0C reads back the mask.
- R6: `irq_o` equals the OR of (pending AND NOT mask). A pending bit stays held while it is masked. Clearing its mask bit raises `irq_o` in the same cycle in which the write takes effect, and setting the mask bit again lowers `irq_o` without clearing the pending bit.
- R7: If a synchronised rising edge and a pending-clear write hit the same bit in the same cycle, the bit stays pending.
- R8: Writes to the status offsets 0x00 and 0x0C change nothing.
- R9: A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 returns zero. Reads of the write-only offsets 0x04, 0x08, 0x10 and 0x14 also return zero.
- R10: With `BIG_ENDIAN` set to 1, bus byte k (bits 8k+7..8k) maps to internal byte 3-k, for both write data and read data. Writing 0x01000000 to offset 0x04 therefore sets source 0, and reading offset 0x00 then returns 0x01000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe; the write takes effect at the next rising edge |
| wdata_i | input | NUM_SRC | Write data |
| rdata_o | output | NUM_SRC | Read data, driven combinationally from `addr_i` |
| src_i | input | NUM_SRC | Asynchronous interrupt sources, one per bit, rising-edge sensitive |
| irq_o | output | 1 | Combined request to the parent controller |

## Verification
Source edges are applied on several bits at once and on a single bit, so that a fault in the per-bit capture shows up as a wrong bit position. Writes to the set and clear words use sparse patterns with some bits set and some not, which separates write-one semantics from plain overwrite. A source that stays high after its bit is acknowledged tells edge capture apart from level capture. A clear write placed exactly on the cycle of a new edge tells whether set or clear has priority. A second instance built with the byte-swap option is driven with a one-byte pattern, so that a swap missing on the write side or on the read side changes the observed position of the byte.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;
  // Register byte offsets; software relies on these positions.
  localparam int unsigned OFF_PEND_STAT = 32'h00;
  localparam int unsigned OFF_PEND_SET  = 32'h04;
  localparam int unsigned OFF_PEND_CLR  = 32'h08;
  localparam int unsigned OFF_MASK_STAT = 32'h0C;
  localparam int unsigned OFF_MASK_SET  = 32'h10;
  localparam int unsigned OFF_MASK_CLR  = 32'h14;
endpackage

// File: rtl/l2irq_sync_edge.sv
module l2irq_sync_edge #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] rise_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;
  logic [WIDTH-1:0]             prev_d, prev_q;

  always_comb begin
    chain_d[0] = async_i;
    for (int k = 1; k < STAGES; k++) begin
      chain_d[k] = chain_q[k-1];
    end
    prev_d = chain_q[LAST];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign rise_o = chain_q[LAST] & ~prev_q;
endmodule

// File: rtl/l2irq_regif.sv
module l2irq_regif
  import l2irq_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter bit          BIG_ENDIAN = 1'b0
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] wdata_n_o,
  output logic [NUM_SRC-1:0] pset_o,
  output logic [NUM_SRC-1:0] pclr_o,
  output logic [NUM_SRC-1:0] mset_o,
  output logic [NUM_SRC-1:0] mclr_o
);
  localparam int unsigned NBYTES = NUM_SRC / 8;

  logic [NUM_SRC-1:0] rdata_n;

  // Byte lane mapping between bus order and internal order.
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    if (BIG_ENDIAN) begin : g_swap
      assign wdata_n_o[8*b +: 8] = wdata_i[8*(NBYTES-1-b) +: 8];
      assign rdata_o[8*b +: 8]   = rdata_n[8*(NBYTES-1-b) +: 8];
    end else begin : g_pass
      assign wdata_n_o[8*b +: 8] = wdata_i[8*b +: 8];
      assign rdata_o[8*b +: 8]   = rdata_n[8*b +: 8];
    end
  end

  logic hit_pset, hit_pclr, hit_mset, hit_mclr;

  always_comb begin
    hit_pset = wr_en_i && (addr_i == ADDR_W'(OFF_PEND_SET));
    hit_pclr = wr_en_i && (addr_i == ADDR_W'(OFF_PEND_CLR));
    hit_mset = wr_en_i && (addr_i == ADDR_W'(OFF_MASK_SET));
    hit_mclr = wr_en_i && (addr_i == ADDR_W'(OFF_MASK_CLR));
    pset_o = hit_pset ? wdata_n_o : '0;
    pclr_o = hit_pclr ? wdata_n_o : '0;
    mset_o = hit_mset ? wdata_n_o : '0;
    mclr_o = hit_mclr ? wdata_n_o : '0;
  end

  always_comb begin
    if (addr_i == ADDR_W'(OFF_PEND_STAT)) begin
      rdata_n = pend_i;
    end else if (addr_i == ADDR_W'(OFF_MASK_STAT)) begin
      rdata_n = mask_i;
    end else begin
      rdata_n = '0;
    end
  end
endmodule

// File: rtl/l2irq_bank.sv
module l2irq_bank #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [NUM_SRC-1:0] pset_i,
  input  logic [NUM_SRC-1:0] pclr_i,
  input  logic [NUM_SRC-1:0] mset_i,
  input  logic [NUM_SRC-1:0] mclr_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] pend_d, pend_q, mask_d, mask_q;
  logic               pend_en, mask_en;

  always_comb begin
    pend_en = |{rise_i, pset_i, pclr_i};
    mask_en = |{mset_i, mclr_i};
    // A fresh edge or a software set outranks an acknowledge.
    pend_d  = (pend_q & ~pclr_i) | pset_i | rise_i;
    mask_d  = (mask_q & ~mclr_i) | mset_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/l2irq_ctrl.sv
module l2irq_ctrl #(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          BIG_ENDIAN  = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_sync;
  logic [NUM_SRC-1:0] rise, pend_q, mask_q, wdata_n;
  logic [NUM_SRC-1:0] pset, pclr, mset, mclr;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  l2irq_sync_edge #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .async_i(src_i),
    .rise_o (rise)
  );

  l2irq_regif #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .BIG_ENDIAN(BIG_ENDIAN)) u_regif (
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .pend_i   (pend_q),
    .mask_i   (mask_q),
    .wdata_n_o(wdata_n),
    .pset_o   (pset),
    .pclr_o   (pclr),
    .mset_o   (mset),
    .mclr_o   (mclr)
  );

  l2irq_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_n_sync),
    .rise_i(rise),
    .pset_i(pset),
    .pclr_i(pclr),
    .mset_i(mset),
    .mclr_i(mclr),
    .pend_o(pend_q),
    .mask_o(mask_q)
  );

  assign irq_o = |(pend_q & ~mask_q);
endmodule

// File: rtl/l2irq_ctrl_chk.sv
module l2irq_ctrl_chk
  import l2irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk_i,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_en_i,
  input logic [NUM_SRC-1:0] wdata_n,
  input logic [NUM_SRC-1:0] rdata_o,
  input logic [NUM_SRC-1:0] rise,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               irq_o
);
  logic clr_wr, mask_wr, pset_wr, mapped;
  assign clr_wr  = wr_en_i && (addr_i == ADDR_W'(OFF_PEND_CLR));
  assign pset_wr = wr_en_i && (addr_i == ADDR_W'(OFF_PEND_SET));
  assign mask_wr = wr_en_i && ((addr_i == ADDR_W'(OFF_MASK_SET)) ||
                               (addr_i == ADDR_W'(OFF_MASK_CLR)));
  assign mapped  = (addr_i == ADDR_W'(OFF_PEND_STAT)) || (addr_i == ADDR_W'(OFF_MASK_STAT));

  // R2: without an acknowledge no pending bit is lost
  assert_pend_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !clr_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R2: a captured edge always lands in its pending bit
  assert_edge_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

  // R4: software set reaches the pending vector
  assert_soft_set_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    pset_wr |=> ((pend_q & $past(wdata_n)) == $past(wdata_n)));

  // R5: mask moves only on a mask write
  assert_mask_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));

  // R6: unmasked pending work raises the line, none lowers it
  assert_irq_level_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((pend_q & ~mask_q) != '0) == irq_o);

  // R7: an edge during an acknowledge survives
  assert_edge_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (clr_wr && ((rise & wdata_n) != '0)) |=> ((pend_q & $past(rise)) == $past(rise)));

  // R9: unmapped offsets read as zero
  assert_unmapped_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !mapped |-> (rdata_o == '0));
endmodule

bind l2irq_ctrl l2irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_n  (rst_n_sync),
  .addr_i (addr_i),
  .wr_en_i(wr_en_i),
  .wdata_n(wdata_n),
  .rdata_o(rdata_o),
  .rise   (rise),
  .pend_q (pend_q),
  .mask_q (mask_q),
  .irq_o  (irq_o)
);

// File: tb/tb_l2irq_ctrl.sv
`timescale 1ns/1ps
module tb_l2irq_ctrl;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0, addr_b = '0;
  logic          wr = 1'b0, wr_b = 1'b0;
  logic [31:0]   wdata = '0, wdata_b = '0, src = '0, src_b = '0;
  logic [31:0]   rdata, rdata_b;
  logic          irq, irq_b;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  l2irq_ctrl #(.NUM_SRC(32), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .irq_o(irq));

  l2irq_ctrl #(.NUM_SRC(32), .ADDR_W(AW), .BIG_ENDIAN(1'b1)) dut_be (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_b), .wr_en_i(wr_b),
    .wdata_i(wdata_b), .rdata_o(rdata_b), .src_i(src_b), .irq_o(irq_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic drive_src(input logic [31:0] v);
    @(negedge clk); src = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd_reg(8'h0C, d); chk("R1 mask after reset", d, 32'hFFFF_FFFF);
    rd_reg(8'h00, d); chk("R1 pending after reset", d, 32'h0);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    drive_src(32'h8000_0011);
    rd_reg(8'h00, d); chk("R2 multi-bit edge capture", d, 32'h8000_0011);
    drive_src(32'h0);
    rd_reg(8'h00, d); chk("R2 pending held after source falls", d, 32'h8000_0011);
    wr_reg(8'h08, 32'h0000_0010);
    rd_reg(8'h00, d); chk("R3 partial acknowledge", d, 32'h8000_0001);
    wr_reg(8'h08, 32'hFFFF_FFFF);
    rd_reg(8'h00, d); chk("R3 full acknowledge", d, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    drive_src(32'h0000_0040);
    wr_reg(8'h08, 32'h0000_0040);
    repeat (4) @(negedge clk);
    rd_reg(8'h00, d); chk("R2 held level does not retrigger", d, 32'h0);
    drive_src(32'h0);
  endtask

  task automatic t_soft_set;
    logic [31:0] d;
    wr_reg(8'h04, 32'h0A00_0500);
    rd_reg(8'h00, d); chk("R4 software set", d, 32'h0A00_0500);
    wr_reg(8'h08, 32'h0A00_0500);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    drive_src(32'h0000_0004);
    chk("R6 masked pending keeps irq low", {31'd0, irq}, 32'd0);
    wr_reg(8'h14, 32'h0000_0004);
    chk("R6 unmask raises irq", {31'd0, irq}, 32'd1);
    rd_reg(8'h0C, d); chk("R5 mask clear readback", d, 32'hFFFF_FFFB);
    wr_reg(8'h10, 32'h0000_0004);
    chk("R6 remask lowers irq", {31'd0, irq}, 32'd0);
    rd_reg(8'h00, d); chk("R6 pending kept while masked", d, 32'h0000_0004);
    rd_reg(8'h0C, d); chk("R5 mask set readback", d, 32'hFFFF_FFFF);
    wr_reg(8'h08, 32'h0000_0004);
    drive_src(32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    wr_reg(8'h04, 32'h0000_0010);
    @(negedge clk); src = 32'h0000_0010;
    @(negedge clk);
    @(negedge clk); addr = 8'h08; wdata = 32'h0000_0010; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    rd_reg(8'h00, d); chk("R7 edge beats acknowledge", d, 32'h0000_0010);
    wr_reg(8'h08, 32'h0000_0010);
    rd_reg(8'h00, d); chk("R3 acknowledge without edge", d, 32'h0);
    drive_src(32'h0);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    wr_reg(8'h04, 32'h0000_0100);
    wr_reg(8'h00, 32'hFFFF_FFFF);
    rd_reg(8'h00, d); chk("R8 write to pending status ignored", d, 32'h0000_0100);
    wr_reg(8'h0C, 32'h0);
    rd_reg(8'h0C, d); chk("R8 write to mask status ignored", d, 32'hFFFF_FFFF);
    chk("R8 irq stays low", {31'd0, irq}, 32'd0);
    rd_reg(8'h18, d); chk("R9 unmapped 0x18 reads zero", d, 32'h0);
    rd_reg(8'h01, d); chk("R9 misaligned 0x01 reads zero", d, 32'h0);
    rd_reg(8'h04, d); chk("R9 write-only 0x04 reads zero", d, 32'h0);
    wr_reg(8'h08, 32'h0000_0100);
  endtask

  task automatic t_big_endian;
    logic [31:0] d;
    @(negedge clk); addr_b = 8'h04; wdata_b = 32'h0100_0000; wr_b = 1'b1;
    @(negedge clk); wr_b = 1'b0; addr_b = 8'h00; #1; d = rdata_b;
    chk("R10 swapped pending readback", d, 32'h0100_0000);
    @(negedge clk); addr_b = 8'h14; wdata_b = 32'h0100_0000; wr_b = 1'b1;
    @(negedge clk); wr_b = 1'b0;
    chk("R10 swapped unmask of source 0", {31'd0, irq_b}, 32'd1);
    addr_b = 8'h0C; #1; d = rdata_b;
    chk("R10 swapped mask readback", d, 32'hFEFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_edges();
    t_level();
    t_soft_set();
    t_mask();
    t_collide();
    t_ignored();
    t_big_endian();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule